// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block arbitrates among eight interrupt sources for a small microcontroller core. Every source carries an individual enable. A single global enable sits above all the individual enables. Each source also carries a two-bit priority, which is formed from one bit of a high-priority register and one bit of a low-priority register. Among the eligible pending requests, the controller presents one to the core as a valid request together with its source index. When the core takes the vector, it pulses an acknowledge. When the handler ends, it pulses a return strobe.

The controller keeps a four-bit in-service mask with one bit per priority level. It uses this mask to decide whether a new request may preempt the handler that is running. Sources 0 and 1 are driven from active-low external pins. Each pin can be set to falling-edge or low-level triggering. In edge mode, a hardware flag latches the event and clears itself when that source is vectored. The remaining six sources are active-high internal request lines.

Top module: `prio_intc`

## Requirements
- R1: A source whose `srcEn` bit is 0 is never reported on `irqIdx` while `irqValid` is 1.
- R2: While `globalEn` is 0, `irqValid` stays 0 whatever the requests and enables.
- R3: A source's rank is {`prioHi[i]`,`prioLo[i]`}. Rank 3 (11) is level 1, the highest. Rank 2 (10) is level 2, rank 1 (01) is level 3, and rank 0 (00) is level 4, the lowest. Among the eligible requests, the one with the highest rank is presented.
- R4: When several eligible requests share the highest rank, the lowest source index is presented.
- R5: A request is presented only if its rank is strictly above every rank in service. A request whose rank equals or is below the highest rank in service waits, and `irqValid` stays 0.
- R6: An `ack` while `irqValid` is 1 marks the presented rank as in service from the next cycle. An `ack` while `irqValid` is 0 changes nothing.
- R7: A `reti` pulse removes the highest rank in the in-service mask. The lower ranks stay in service.
- R8: Source k (k = 0, 1) follows active-low pin `extPinN[k]`. With `trigEdge[k]` = 1, a falling edge, seen after a two-flop synchronizer, sets a flag. The flag keeps the request pending after the pin returns high, and it clears when that source is acknowledged.
- R9: With `trigEdge[k]` = 0, source k is pending exactly while the synchronized pin is low. Nothing is latched, so a request withdrawn before it is acknowledged disappears.
- R10: Internal request `intReq[j]` is source j+2 and is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPinN | input | 2 | Active-low external interrupt pins (sources 0, 1) |
| trigEdge | input | 2 | Trigger select per pin: 1 = falling edge, 0 = low level |
| intReq | input | 6 | Active-high internal requests (sources 2..7) |
| srcEn | input | 8 | Per-source enable |
| globalEn | input | 1 | Global enable |
| prioHi | input | 8 | High bit of each source's rank |
| prioLo | input | 8 | Low bit of each source's rank |
| ack | input | 1 | Vector taken for the presented request |
| reti | input | 1 | Return from interrupt |
| irqValid | output | 1 | A request may be vectored now |
| irqIdx | output | 3 | Index of the presented source |

## Verification
The assertions check the rules that hold on every cycle. No disabled source is presented, and the global mask silences the output. A presented request always outranks every level in service. An accepted acknowledge records its rank, and a lone return removes exactly one level. The tie break by lowest index, the exact level encoding, and the choice of which level a return clears can only be shown by the bench. It does this with sweeps over request, enable and priority patterns, and with nested acknowledge and return sequences. The same holds for the synchronizer delay, and for the difference between a latched edge flag and a transient low level on the pins.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int LEVELS = 4;
  localparam int RANK_W = 2;

  typedef struct packed {
    logic take;    // accepted acknowledge this cycle
    logic retire;  // drop highest in-service level
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_EXT     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_EXT-1:0]        extPinN,
  input  logic [NUM_EXT-1:0]        trigEdge,
  input  logic [NUM_SRC-NUM_EXT-1:0] intReq,
  input  logic [NUM_SRC-1:0]        srcEn,
  input  logic                      globalEn,
  input  logic [NUM_SRC-1:0]        prioHi,
  input  logic [NUM_SRC-1:0]        prioLo,
  input  ctrlStrobe_t               strobe,
  output logic                      anyPend,
  output logic [IDX_W-1:0]          winIdx,
  output logic [RANK_W-1:0]         winRank
);
  logic [SYNC_STAGES-1:0][NUM_EXT-1:0] syncStage;
  logic [NUM_EXT-1:0] pinSync, prevSample, fallDet, edgeFlag;
  logic [NUM_SRC-1:0] pending, eligible;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage  <= '1;
      prevSample <= '1;
    end else begin
      syncStage  <= {syncStage[SYNC_STAGES-2:0], extPinN};
      prevSample <= pinSync;
    end
  end

  assign pinSync = syncStage[SYNC_STAGES-1];
  assign fallDet = prevSample & ~pinSync;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   edgeFlag[k] <= 1'b0;
      else if (!trigEdge[k])                       edgeFlag[k] <= 1'b0;
      else if (fallDet[k])                         edgeFlag[k] <= 1'b1;
      else if (strobe.take && winIdx == IDX_W'(k)) edgeFlag[k] <= 1'b0;
    end
    assign pending[k] = trigEdge[k] ? edgeFlag[k] : ~pinSync[k];
  end

  assign pending[NUM_SRC-1:NUM_EXT] = intReq;
  assign eligible = pending & srcEn & {NUM_SRC{globalEn}};

  // highest rank wins; strict compare in ascending order keeps lowest index on ties
  always_comb begin
    anyPend = 1'b0;
    winIdx  = '0;
    winRank = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!anyPend || {prioHi[i], prioLo[i]} > winRank)) begin
        anyPend = 1'b1;
        winIdx  = IDX_W'(i);
        winRank = {prioHi[i], prioLo[i]};
      end
    end
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import prio_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyPend,
  input  logic [RANK_W-1:0] winRank,
  input  logic              ack,
  input  logic              reti,
  output logic              irqValid,
  output logic [LEVELS-1:0] inSvc,
  output ctrlStrobe_t       strobe
);
  logic              blocked;
  logic [LEVELS-1:0] topBit, setBit;

  always_comb begin
    blocked = 1'b0;
    topBit  = '0;
    for (int r = 0; r < LEVELS; r++) begin
      if (inSvc[r] && r >= int'(winRank)) blocked = 1'b1;
      if (inSvc[r]) topBit = LEVELS'(1) << r;
    end
  end

  assign irqValid      = anyPend && !blocked;
  assign strobe.take   = ack && irqValid;
  assign strobe.retire = reti;
  assign setBit        = LEVELS'(1) << winRank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inSvc <= '0;
    else inSvc <= (inSvc & ~(strobe.retire ? topBit : '0))
                | (strobe.take ? setBit : '0);
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_EXT     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extPinN,
  input  logic [NUM_EXT-1:0]         trigEdge,
  input  logic [NUM_SRC-NUM_EXT-1:0] intReq,
  input  logic [NUM_SRC-1:0]         srcEn,
  input  logic                       globalEn,
  input  logic [NUM_SRC-1:0]         prioHi,
  input  logic [NUM_SRC-1:0]         prioLo,
  input  logic                       ack,
  input  logic                       reti,
  output logic                       irqValid,
  output logic [IDX_W-1:0]           irqIdx
);
  ctrlStrobe_t       strobe;
  logic              anyPend;
  logic [RANK_W-1:0] winRank;
  logic [LEVELS-1:0] inSvc;

  intc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .trigEdge(trigEdge),
    .intReq(intReq), .srcEn(srcEn), .globalEn(globalEn),
    .prioHi(prioHi), .prioLo(prioLo), .strobe(strobe),
    .anyPend(anyPend), .winIdx(irqIdx), .winRank(winRank)
  );

  intc_control u_ctrl (
    .clk(clk), .rstN(rstN), .anyPend(anyPend), .winRank(winRank),
    .ack(ack), .reti(reti), .irqValid(irqValid), .inSvc(inSvc),
    .strobe(strobe)
  );
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEn,
  input logic               globalEn,
  input logic [NUM_SRC-1:0] prioHi,
  input logic [NUM_SRC-1:0] prioLo,
  input logic               ack,
  input logic               reti,
  input logic               irqValid,
  input logic [IDX_W-1:0]   irqIdx,
  input logic [3:0]         inSvc
);
  logic [1:0] shownRank;
  assign shownRank = {prioHi[irqIdx], prioLo[irqIdx]};

  AST_DISABLED_NEVER_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> srcEn[irqIdx]); // R1
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqValid); // R2
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((inSvc >> shownRank) == 4'b0)); // R5
  AST_ACK_RECORDS: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqValid) |=> inSvc[$past(shownRank)]); // R6
  AST_IDLE_ACK_NOOP: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !irqValid && !reti) |=> $stable(inSvc)); // R6
  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (reti && !ack && inSvc != 4'b0) |=> ($countones(inSvc) == $countones($past(inSvc)) - 1)); // R7
endmodule

bind prio_intc prio_intc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .srcEn(srcEn), .globalEn(globalEn),
  .prioHi(prioHi), .prioLo(prioLo), .ack(ack), .reti(reti),
  .irqValid(irqValid), .irqIdx(irqIdx), .inSvc(inSvc)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extPinN = 2'b11;
  logic [1:0] trigEdge = 2'b11;
  logic [5:0] intReq = '0;
  logic [7:0] srcEn = '0;
  logic       globalEn = 1'b0;
  logic [7:0] prioHi = '0;
  logic [7:0] prioLo = '0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       irqValid;
  logic [2:0] irqIdx;

  int total = 0;
  int bad = 0;

  always #(CYC/2) clk = ~clk;

  prio_intc uut (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .trigEdge(trigEdge),
    .intReq(intReq), .srcEn(srcEn), .globalEn(globalEn),
    .prioHi(prioHi), .prioLo(prioLo), .ack(ack), .reti(reti),
    .irqValid(irqValid), .irqIdx(irqIdx)
  );

  task automatic check(input string req, input bit expV, input int expIdx);
    total++;
    if (irqValid !== expV || (expV && irqIdx !== 3'(expIdx))) begin
      bad++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               req, irqValid, irqIdx, expV, expIdx);
    end
  endtask

  // drive at the falling edge, settle, then observe
  task automatic settle();
    @(negedge clk); #2;
  endtask

  task automatic pulseAck();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #2;
  endtask

  task automatic pulseReti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0; #2;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic setRank(input int src, input int rank);
    prioHi[src] = rank[1];
    prioLo[src] = rank[0];
  endtask

  // model: nothing in service, external sources idle
  task automatic expectSweep(output bit v, output int idx);
    int best = -1;
    v = 0; idx = 0;
    for (int i = 2; i < 8; i++) begin
      int r = prioHi[i] * 2 + prioLo[i];
      if (intReq[i-2] && srcEn[i] && globalEn && r > best) begin
        best = r; idx = i; v = 1;
      end
    end
  endtask

  initial begin
    #(CYC * 100000);
    bad++;
    $display("FAIL watchdog: valid=%0b idx=%0d expected completion", irqValid, irqIdx);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2345;
    bit ev; int ei;

    waitCycles(3);
    check("reset R2", 0, 0);
    rstN = 1'b1;
    waitCycles(3);
    check("after reset R1", 0, 0);

    // sweep over internal sources: R1 R2 R3 R4 R10
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      @(negedge clk);
      intReq   = lfsr[5:0];
      srcEn    = lfsr[13:6] | 8'h03;
      prioHi   = lfsr[21:14] & lfsr[31:24];
      prioLo   = lfsr[29:22];
      globalEn = (lfsr[31:30] != 2'b00);
      #2;
      expectSweep(ev, ei);
      check("sweep R3/R4/R1/R2/R10", ev, ei);
    end

    // nested preemption
    @(negedge clk);
    srcEn = 8'hFF; globalEn = 1'b1; intReq = '0; prioHi = '0; prioLo = '0;
    setRank(2, 1); setRank(3, 1); setRank(4, 2); setRank(5, 3); setRank(6, 0);
    intReq = 6'b000011; #2;               // sources 2,3 at rank 1
    check("tie lowest index R4", 1, 2);
    pulseAck();
    check("equal rank waits R5", 0, 0);
    @(negedge clk); intReq = 6'b000111; #2; // add source 4 rank 2
    check("higher rank preempts R5", 1, 4);
    pulseAck();
    check("ack records rank R6", 0, 0);
    @(negedge clk); intReq = 6'b001111; #2; // add source 5 rank 3
    check("top rank preempts R3", 1, 5);
    pulseAck();
    check("all levels blocked R5", 0, 0);
    pulseReti();
    check("reti clears rank 3 R7", 1, 5);
    @(negedge clk); intReq = 6'b000111; #2;
    check("rank 2 still in service R7", 0, 0);
    pulseReti();
    check("reti clears rank 2 not 1 R7", 1, 4);
    @(negedge clk); globalEn = 1'b0; #2;
    check("global mask R2", 0, 0);
    @(negedge clk); globalEn = 1'b1; srcEn[4] = 1'b0; #2;
    check("disabled source skipped R1", 0, 0);
    pulseReti();
    check("ranks empty R7", 1, 2);
    @(negedge clk); intReq = '0; srcEn = 8'hFF; #2;
    pulseAck();
    @(negedge clk); intReq = 6'b010000; #2; // source 6 rank 0
    check("idle ack ignored R6", 1, 6);
    @(negedge clk); intReq = '0;

    // edge-triggered pin: R8
    setRank(0, 3); setRank(1, 3);
    @(negedge clk); trigEdge = 2'b11; extPinN[0] = 1'b0; #2;
    check("edge not yet through sync R8", 0, 0);
    waitCycles(4);
    check("edge flag set R8", 1, 0);
    @(negedge clk); extPinN[0] = 1'b1;
    waitCycles(4);
    check("edge flag holds after pin high R8", 1, 0);
    pulseAck();
    pulseReti();
    check("edge flag cleared by ack R8", 0, 0);

    // level-triggered pin: R9
    @(negedge clk); trigEdge[1] = 1'b0; extPinN[1] = 1'b0;
    waitCycles(4);
    check("low level requests R9", 1, 1);
    pulseAck();
    pulseReti();
    check("level persists while low R9", 1, 1);
    @(negedge clk); extPinN[1] = 1'b1;
    waitCycles(4);
    check("level withdrawn R9", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule